// File: doc/BRIEF.md
# Panel Self-Refresh State Sequencer

This block holds the source-side self-refresh state of one display pipe. It steps through six numbered states: disabled, inactive, entering, active, active with a single-frame update, and exiting. Software moves it through some transitions with level control bits, and hardware events from the link and pixel path complete the rest. The current state is published as a 3-bit code, together with an in-transition flag, a self-refresh-active flag and a pending single-frame-update flag.

Software first raises `ctl_enable`, which takes the block from 0 to 1. It then raises `ctl_entry` to start entry, state 2. While in state 2 the static frame goes out, and `ev_static_sent` completes entry into state 3. A single-frame request, pulsed on `sfu_req` before a flip, sends an active pipe through state 4. That request clears itself once the block is back in state 3.

Dropping `ctl_entry` in state 3 goes straight to the exit state 5 and does not pass through state 4. On arrival in state 5 the block raises `wake_strobe` for `WAKE_LEN` cycles. The link layer answers the strobe by writing the power-on value 01h to sink register 600h. Once the strobe has finished, `ev_exit_done` returns the block to state 1. Dropping `ctl_enable` is honoured only while no transition is in flight, and it returns the block to state 0. Every transition happens at the clock edge on which its inputs are sampled.

Top module: `selfref_seq`

## Requirements
- R1: After reset the state code is 0 and `in_trans`, `sr_active`, `wake_strobe` and `sfu_pending` are all low.
- R2: In state 0 only `ctl_enable` high changes the state, to 1. `ctl_entry`, `sfu_req` and the three event inputs have no effect there.
- R3: In state 1, `ctl_enable` low goes to 0. Otherwise `ctl_entry` high goes to 2. With neither, the state stays 1.
- R4: In state 2, `ev_static_sent` goes to state 3. `sr_active` is high exactly when the state is 3 or 4.
- R5: In state 3, with enable and entry both high, a set pending flag moves the state to 4. In state 4, `ev_update_done` returns it to 3.
- R6: In state 3, `ctl_entry` low with `ctl_enable` high goes directly to 5. `wake_strobe` is high for exactly `WAKE_LEN` consecutive cycles, starting in the first cycle that shows state 5, and at no other time.
- R7: In state 5, `ev_exit_done` goes to 1 only on an edge at which `wake_strobe` is already low. While the strobe is high the event is ignored.
- R8: `ctl_enable` low is honoured only in states 1 and 3, where it goes to 0. In states 2, 4 and 5 it is ignored and the state does not change.
- R9: `in_trans` is high exactly in states 2, 4 and 5.
- R10: In state 3 the priority is disable first, then exit, then single-frame update.
- R11: `sfu_req` sets `sfu_pending` only in states 1, 2 and 3 and is ignored in 0, 4 and 5. `sfu_pending` clears on the edge at which the state enters 3 from another state, or enters 0. Either clear beats a request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_enable | input | 1 | Software enable level |
| ctl_entry | input | 1 | Software active-entry level |
| sfu_req | input | 1 | Single-frame-update request pulse |
| ev_static_sent | input | 1 | Static frame has been sent |
| ev_update_done | input | 1 | Single-frame update finished |
| ev_exit_done | input | 1 | Link reports exit finished |
| state_code | output | 3 | Current state, 0 to 5 |
| in_trans | output | 1 | Transition in progress |
| sr_active | output | 1 | Self-refresh active (state 3 or 4) |
| wake_strobe | output | 1 | Request to send the sink wake write |
| sfu_pending | output | 1 | Single-frame request waiting |

## Verification
In state 3 the disable, exit and single-frame-update paths can all be selected on the same edge. A request pulse can also land on the very edge that carries state 2 into state 3, so the self-clear and a new set meet. The bench steers the block into each of the six states and applies all 64 combinations of the six inputs there. It then judges the next state and every flag against its own transition model, and follows with a long pseudo-random run in which the wake counter and the exit event overlap in every order.

// File: rtl/selfref_pkg.sv
package selfref_pkg;

   localparam int unsigned SFR_STATE_W = 3;

   typedef enum logic [SFR_STATE_W-1:0] {
      SFR_OFF    = 3'd0,
      SFR_IDLE   = 3'd1,
      SFR_ENTRY  = 3'd2,
      SFR_ACTIVE = 3'd3,
      SFR_SFU    = 3'd4,
      SFR_EXIT   = 3'd5
   } sfr_state_e;

endpackage

// File: rtl/sfr_fsm.sv
module sfr_fsm
   import selfref_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_enable,
   input  logic       ctl_entry,
   input  logic       ev_static_sent,
   input  logic       ev_update_done,
   input  logic       ev_exit_done,
   input  logic       upd_pending,
   input  logic       wake_done,
   output sfr_state_e st_q,
   output sfr_state_e st_d
);

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         SFR_OFF: begin
            if (ctl_enable) st_d = SFR_IDLE;
         end
         SFR_IDLE: begin
            if (!ctl_enable)    st_d = SFR_OFF;
            else if (ctl_entry) st_d = SFR_ENTRY;
         end
         SFR_ENTRY: begin
            if (ev_static_sent) st_d = SFR_ACTIVE;
         end
         SFR_ACTIVE: begin
            if (!ctl_enable)      st_d = SFR_OFF;
            else if (!ctl_entry)  st_d = SFR_EXIT;
            else if (upd_pending) st_d = SFR_SFU;
         end
         SFR_SFU: begin
            if (ev_update_done) st_d = SFR_ACTIVE;
         end
         SFR_EXIT: begin
            if (ev_exit_done && wake_done) st_d = SFR_IDLE;
         end
         default: st_d = SFR_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= SFR_OFF;
      else        st_q <= st_d;
   end

   // R2
   off_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SFR_OFF) |=> (st_q == SFR_OFF || st_q == SFR_IDLE));

   // R6
   exit_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SFR_ACTIVE && ctl_enable && !ctl_entry) |=> (st_q == SFR_EXIT));

   // R8
   busy_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == SFR_ENTRY || st_q == SFR_SFU || st_q == SFR_EXIT) && !ctl_enable)
      |=> (st_q != SFR_OFF));

   // R1
   legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q <= SFR_EXIT));

endmodule

// File: rtl/sfr_pend.sv
module sfr_pend
   import selfref_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sfu_req,
   input  sfr_state_e st_q,
   input  sfr_state_e st_d,
   output logic       pend_q
);

   logic arrive_active;
   logic req_ok;

   assign arrive_active = (st_d == SFR_ACTIVE) && (st_q != SFR_ACTIVE);
   assign req_ok        = sfu_req && (st_q == SFR_IDLE || st_q == SFR_ENTRY ||
                                      st_q == SFR_ACTIVE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 pend_q <= 1'b0;
      else if (arrive_active)     pend_q <= 1'b0;
      else if (st_d == SFR_OFF)   pend_q <= 1'b0;
      else if (req_ok)            pend_q <= 1'b1;
   end

   // R11
   pend_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SFR_ACTIVE && $past(st_q) != SFR_ACTIVE) |-> !pend_q);

   // R11
   pend_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == SFR_OFF || st_q == SFR_SFU || st_q == SFR_EXIT) && !pend_q)
      |=> !pend_q);

endmodule

// File: rtl/sfr_wake.sv
module sfr_wake
   import selfref_pkg::*;
#(
   parameter int unsigned WAKE_LEN = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  sfr_state_e st_q,
   input  sfr_state_e st_d,
   output logic       wake_o,
   output logic       wake_done
);

   localparam int unsigned CNT_W = $clog2(WAKE_LEN + 1);

   if (WAKE_LEN < 1 || WAKE_LEN > 255) begin : g_bad_len
      $error("sfr_wake: WAKE_LEN must lie in 1..255");
   end

   logic arrive_exit;
   assign arrive_exit = (st_d == SFR_EXIT) && (st_q != SFR_EXIT);

   if (WAKE_LEN == 1) begin : g_single
      logic wk_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) wk_q <= 1'b0;
         else        wk_q <= arrive_exit;
      end
      assign wake_o    = wk_q;
      assign wake_done = !wk_q;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)             cnt_q <= '0;
         else if (arrive_exit)   cnt_q <= CNT_W'(WAKE_LEN);
         else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
      end
      assign wake_o    = (cnt_q != '0);
      assign wake_done = (cnt_q == '0);
   end

   // R6
   wake_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> (st_q == SFR_EXIT));

   // R6
   wake_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == SFR_EXIT && $past(st_q) != SFR_EXIT) |-> wake_o);

endmodule

// File: rtl/sfr_status.sv
module sfr_status
   import selfref_pkg::*;
(
   input  sfr_state_e st_q,
   output logic       in_trans,
   output logic       sr_active
);

   always_comb begin
      in_trans  = 1'b0;
      sr_active = 1'b0;
      unique case (st_q)
         SFR_ENTRY:  in_trans  = 1'b1;
         SFR_ACTIVE: sr_active = 1'b1;
         SFR_SFU: begin
            in_trans  = 1'b1;
            sr_active = 1'b1;
         end
         SFR_EXIT:   in_trans  = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/selfref_seq.sv
module selfref_seq
   import selfref_pkg::*;
#(
   parameter int unsigned WAKE_LEN = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   ctl_enable,
   input  logic                   ctl_entry,
   input  logic                   sfu_req,
   input  logic                   ev_static_sent,
   input  logic                   ev_update_done,
   input  logic                   ev_exit_done,
   output logic [SFR_STATE_W-1:0] state_code,
   output logic                   in_trans,
   output logic                   sr_active,
   output logic                   wake_strobe,
   output logic                   sfu_pending
);

   sfr_state_e st_q;
   sfr_state_e st_d;
   logic       pend_q;
   logic       wake_done;

   sfr_fsm u_fsm (
      .clk            (clk),
      .rst_n          (rst_n),
      .ctl_enable     (ctl_enable),
      .ctl_entry      (ctl_entry),
      .ev_static_sent (ev_static_sent),
      .ev_update_done (ev_update_done),
      .ev_exit_done   (ev_exit_done),
      .upd_pending    (pend_q),
      .wake_done      (wake_done),
      .st_q           (st_q),
      .st_d           (st_d)
   );

   sfr_pend u_pend (
      .clk     (clk),
      .rst_n   (rst_n),
      .sfu_req (sfu_req),
      .st_q    (st_q),
      .st_d    (st_d),
      .pend_q  (pend_q)
   );

   sfr_wake #(.WAKE_LEN(WAKE_LEN)) u_wake (
      .clk       (clk),
      .rst_n     (rst_n),
      .st_q      (st_q),
      .st_d      (st_d),
      .wake_o    (wake_strobe),
      .wake_done (wake_done)
   );

   sfr_status u_status (
      .st_q      (st_q),
      .in_trans  (in_trans),
      .sr_active (sr_active)
   );

   assign state_code  = st_q;
   assign sfu_pending = pend_q;

   // R4
   entry_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd2 && ev_static_sent) |=> (state_code == 3'd3 && sr_active));

   // R9
   flag_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_trans && sr_active) |-> (state_code == 3'd4));

   // R7
   early_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_code == 3'd5 && wake_strobe) |=> (state_code == 3'd5));

endmodule

// File: tb/selfref_seq_bench.sv
module selfref_seq_bench;

   localparam int CLK_PERIOD = 10;
   localparam int WL         = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctl_enable = 1'b0, ctl_entry = 1'b0, sfu_req = 1'b0;
   logic       ev_static_sent = 1'b0, ev_update_done = 1'b0, ev_exit_done = 1'b0;
   logic [2:0] state_code;
   logic       in_trans, sr_active, wake_strobe, sfu_pending;

   int checks = 0;
   int fails  = 0;

   int m_st   = 0;
   int m_wk   = 0;
   bit m_pend = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   selfref_seq #(.WAKE_LEN(WL)) u_selfref_seq (
      .clk(clk), .rst_n(rst_n), .ctl_enable(ctl_enable), .ctl_entry(ctl_entry),
      .sfu_req(sfu_req), .ev_static_sent(ev_static_sent),
      .ev_update_done(ev_update_done), .ev_exit_done(ev_exit_done),
      .state_code(state_code), .in_trans(in_trans), .sr_active(sr_active),
      .wake_strobe(wake_strobe), .sfu_pending(sfu_pending)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // c[0] enable, c[1] entry, c[2] sfu_req, c[3] static, c[4] update, c[5] exit
   task automatic model_step(input logic [5:0] c);
      int nx = m_st;
      case (m_st)
         0: if (c[0]) nx = 1;
         1: if (!c[0]) nx = 0; else if (c[1]) nx = 2;
         2: if (c[3]) nx = 3;
         3: if (!c[0]) nx = 0; else if (!c[1]) nx = 5; else if (m_pend) nx = 4;
         4: if (c[4]) nx = 3;
         5: if (c[5] && m_wk == 0) nx = 1;
         default: nx = 0;
      endcase
      if (nx == 3 && m_st != 3) m_pend = 1'b0;
      else if (nx == 0)         m_pend = 1'b0;
      else if (c[2] && (m_st == 1 || m_st == 2 || m_st == 3)) m_pend = 1'b1;
      if (nx == 5 && m_st != 5) m_wk = WL;
      else if (m_wk != 0)       m_wk = m_wk - 1;
      m_st = nx;
   endtask

   task automatic compare(input int prev);
      string st_tag;
      case (prev)
         0: st_tag = "R2";
         1: st_tag = "R3";
         2: st_tag = "R4";
         3: st_tag = "R10";
         4: st_tag = "R5";
         default: st_tag = "R7";
      endcase
      chk({st_tag, " state"}, int'(state_code), m_st);
      chk("R9 in_trans", int'(in_trans), int'(m_st == 2 || m_st == 4 || m_st == 5));
      chk("R4 sr_active", int'(sr_active), int'(m_st == 3 || m_st == 4));
      chk("R6 wake_strobe", int'(wake_strobe), int'(m_wk != 0));
      chk("R11 sfu_pending", int'(sfu_pending), int'(m_pend));
   endtask

   task automatic drive(input logic [5:0] c);
      int prev;
      @(negedge clk);
      ctl_enable     = c[0];
      ctl_entry      = c[1];
      sfu_req        = c[2];
      ev_static_sent = c[3];
      ev_update_done = c[4];
      ev_exit_done   = c[5];
      @(posedge clk);
      prev = m_st;
      model_step(c);
      #1;
      compare(prev);
   endtask

   task automatic do_reset;
      @(negedge clk);
      rst_n = 1'b0;
      {ctl_enable, ctl_entry, sfu_req, ev_static_sent, ev_update_done, ev_exit_done} = '0;
      repeat (2) @(posedge clk);
      m_st = 0; m_wk = 0; m_pend = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic steer(input int k);
      if (k >= 1) drive(6'b000001);
      if (k >= 2) drive(6'b000011);
      if (k >= 3) drive(6'b001011);
      if (k == 4) begin
         drive(6'b000111);
         drive(6'b000011);
      end
      if (k == 5) drive(6'b000001);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      do_reset();
      #1;
      // R1 reset values
      chk("R1 state", int'(state_code), 0);
      chk("R1 flags", int'({in_trans, sr_active, wake_strobe, sfu_pending}), 0);

      // R8 disable ignored while entering, honoured while inactive
      steer(2);
      drive(6'b000000);
      chk("R8 disable in state 2", int'(state_code), 2);
      do_reset();
      steer(1);
      drive(6'b000000);
      chk("R8 disable in state 1", int'(state_code), 0);

      // R6 exit skips state 4 even with a request pending
      do_reset();
      steer(3);
      drive(6'b000111);
      drive(6'b000001);
      chk("R6 direct exit", int'(state_code), 5);

      // R10 R11 exhaustive input sweep from every state
      for (int k = 0; k < 6; k++) begin
         for (int c = 0; c < 64; c++) begin
            do_reset();
            steer(k);
            drive(6'(c));
            drive(6'(c));
         end
      end

      // R7 pseudo-random run covering exit timing against wake strobe
      do_reset();
      begin
         logic [15:0] r = 16'hACE1;
         logic        ent = 1'b0;
         for (int i = 0; i < 4000; i++) begin
            logic [5:0] c;
            r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
            if (r[7:5] == 3'd0) ent = ~ent;
            c[0] = (r[3:0] != 4'd0);
            c[1] = ent;
            c[2] = r[8] & r[9];
            c[3] = r[10];
            c[4] = r[11];
            c[5] = r[12];
            drive(c);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule